// File: doc/BRIEF.md
# Synchronous Memory-Card Serial Engine

This block is the card-side protocol engine of a two-wire synchronous memory card. It watches a card reset line, a card clock and a shared open-drain data line. It answers a reset by streaming the first four bytes of its main store. It receives three-byte commands framed by start and stop conditions on the data line. It streams either the 256-byte main store or the 32-bit protection store back to the host, always from the requested point to the end. Commands that change memory are not executed here. They are passed to a separate update block through a request/done handshake, and during that time the data line is held low to show that work is in progress.

The card lines are slow compared with the system clock, so all three are sampled on the system clock and their edges are detected. The data line is modelled as an output-enable plus a data value. When the enable is off, the line is released and the external pull-up makes it read as 1. The store is kept in register arrays. The update block writes those arrays through a plain write port.

Top module: `mcard_engine`

## Requirements
- R1: After system reset the data line is released (`io_oe`=0), `upd_req` is 0, and the engine waits for a start condition.
- R2: `io_oe` and `io_out` change only after a detected falling edge of `card_clk`, or after an edge of `card_rst`. They never change during a `card_clk` high phase.
- R3: If `card_clk` rises at least once while `card_rst` is high, then the falling edge of `card_rst` drives bit 0 of byte 0. Each of the next 31 falling clock edges drives the next bit of bytes 0 to 3, LSB first. The 32nd falling edge releases the line.
- R4: A start condition (data falls while `card_clk` is high) begins command reception. Data is sampled on each `card_clk` rising edge into a 24-bit frame, LSB first: bits 7:0 are the control byte, bits 15:8 the address and bits 23:16 the data. The frame is accepted only if the stop condition (data rises while `card_clk` is high) arrives during the 25th clock high phase. The line stays released throughout reception.
- R5: Control 0x30 with address n streams main-store bits from n·8 up to bit 2047, LSB first within each byte. The first bit appears on the first falling edge after the stop condition, and the falling edge after the last bit releases the line.
- R6: Control 0x34 streams protection bits 0 to 31 in index order, with the same first-bit and release timing as R5.
- R7: Controls 0x38 and 0x3C raise `upd_req` with the address and data bytes, and `upd_prot`=1 only for 0x3C. The line is driven low on the next falling edge. `upd_req` and its fields hold until `upd_done`. The first falling edge after `upd_done` that finds the line low releases it.
- R8: Start and stop conditions are ignored during answer-to-reset streaming, outgoing data and processing.
- R9: While `card_rst` is high the line is released on the next system clock and any request is withdrawn. If no `card_clk` rise occurred while `card_rst` was high, its falling edge returns the engine to idle with no answer-to-reset.
- R10: An unknown control byte, or a frame whose stop condition does not fall in the 25th clock, leaves the line released and `upd_req` low. The engine then waits for a new start condition.
- R11: A write on the store port (`mem_wr_prot`=0: the byte at `mem_wr_addr`; `mem_wr_prot`=1: protection bit `mem_wr_addr` set to `mem_wr_data[0]`) is seen by later reads. After reset every main byte is 0xFF and every protection bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low |
| card_rst | input | 1 | Card reset line |
| card_clk | input | 1 | Card clock line |
| io_in | input | 1 | Sensed level of the shared data line |
| io_oe | output | 1 | Data line drive enable (0 = released) |
| io_out | output | 1 | Data value driven when enabled |
| upd_req | output | 1 | Update request to the write/erase block |
| upd_prot | output | 1 | Request targets the protection store |
| upd_addr | output | ADDR_W | Address byte of the update command |
| upd_data | output | 8 | Data byte of the update command |
| upd_done | input | 1 | Pulse from the update block when finished |
| mem_wr_en | input | 1 | Store write strobe |
| mem_wr_prot | input | 1 | Store write selects protection store |
| mem_wr_addr | input | ADDR_W | Store write address |
| mem_wr_data | input | 8 | Store write data |

## Verification
The bench injects start/stop pulses on the data line while the card is streaming a 1. A design that recognised them would abandon the stream, and the remaining bits would be wrong. Frames with 23 and 25 clocks, and an unknown control byte, must leave the line silent. An engine that decoded regardless would start driving data or raise a request. A break in the middle of a read must release the line at once and must not start an answer-to-reset. A read that ends at the top of the store checks the exact release clock, which catches an off-by-one in the end pointer. The update test holds `upd_done` back over several clocks to confirm that the busy-low line and the request fields stay put.

// File: rtl/mcard_pkg.sv
package mcard_pkg;

    typedef enum logic [2:0] {
        MD_IDLE = 3'd0,
        MD_HOLD = 3'd1,
        MD_ATR  = 3'd2,
        MD_RECV = 3'd3,
        MD_OUT  = 3'd4,
        MD_PROC = 3'd5
    } mode_e;

    localparam logic [7:0] CTL_RD_MAIN  = 8'h30;
    localparam logic [7:0] CTL_UPD_MAIN = 8'h38;
    localparam logic [7:0] CTL_RD_PROT  = 8'h34;
    localparam logic [7:0] CTL_WR_PROT  = 8'h3C;

    localparam int CMD_BITS = 24;

endpackage

// File: rtl/mcard_sync.sv
// Samples slow card lines on the system clock and flags their edges.
module mcard_sync #(
    parameter int           W    = 3,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] now_q, old_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_q <= INIT;
            old_q <= INIT;
        end else begin
            now_q <= raw;
            old_q <= now_q;
        end
    end

    assign cur  = now_q;
    assign rise = now_q & ~old_q;
    assign fall = ~now_q & old_q;
endmodule

// File: rtl/mcard_store.sv
// Main byte store and protection bit store, single-bit read by bit index.
module mcard_store #(
    parameter int ADDR_W    = 8,
    parameter int PROT_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_prot,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_prot,
    input  logic [ADDR_W+2:0] rd_idx,
    output logic              rd_bit
);
    localparam int DEPTH  = 2 ** ADDR_W;
    localparam int PIDX_W = $clog2(PROT_BITS);

    logic [7:0]           main_q [DEPTH];
    logic [PROT_BITS-1:0] prot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) main_q[i] <= 8'hFF;
            prot_q <= '1;
        end else if (wr_en) begin
            if (!wr_prot) begin
                main_q[wr_addr] <= wr_data;
            end else if (int'(wr_addr) < PROT_BITS) begin
                prot_q[wr_addr[PIDX_W-1:0]] <= wr_data[0];
            end
        end
    end

    always_comb begin
        if (rd_prot) rd_bit = prot_q[rd_idx[PIDX_W-1:0]];
        else         rd_bit = main_q[rd_idx[ADDR_W+2:3]][rd_idx[2:0]];
    end
endmodule

// File: rtl/mcard_engine.sv
module mcard_engine
    import mcard_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PROT_BITS = 32,
    parameter int ATR_BITS  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_rst,
    input  logic              card_clk,
    input  logic              io_in,
    output logic              io_oe,
    output logic              io_out,
    output logic              upd_req,
    output logic              upd_prot,
    output logic [ADDR_W-1:0] upd_addr,
    output logic [7:0]        upd_data,
    input  logic              upd_done,
    input  logic              mem_wr_en,
    input  logic              mem_wr_prot,
    input  logic [ADDR_W-1:0] mem_wr_addr,
    input  logic [7:0]        mem_wr_data
);
    localparam int IDX_W      = ADDR_W + 3;
    localparam int PTR_W      = IDX_W + 1;
    localparam int MAIN_BITS  = 2 ** IDX_W;
    localparam int FRAME_CLKS = CMD_BITS + 1;
    localparam int CNT_W      = $clog2(FRAME_CLKS + 2);

    typedef struct packed {
        mode_e               mode;
        logic [PTR_W-1:0]    ptr;
        logic [PTR_W-1:0]    last;
        logic                src_prot;
        logic                first;
        logic [CMD_BITS-1:0] shreg;
        logic [CNT_W-1:0]    cnt;
        logic                atr_arm;
        logic                io_oe;
        logic                io_out;
        logic                upd_req;
        logic                upd_prot;
        logic [ADDR_W-1:0]   upd_addr;
        logic [7:0]          upd_data;
        logic                done_seen;
    } eng_st_t;

    eng_st_t state_q, state_d;

    // Line sampling: bit 2 data, bit 1 card reset, bit 0 card clock
    logic [2:0] ln_cur, ln_rise, ln_fall;
    mcard_sync #(.W(3), .INIT(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({io_in, card_rst, card_clk}),
        .cur  (ln_cur),
        .rise (ln_rise),
        .fall (ln_fall)
    );

    logic clk_cur, clk_rise, clk_fall, rst_cur, rst_rise, rst_fall, io_cur;
    logic start_c, stop_c;
    assign clk_cur  = ln_cur[0];
    assign clk_rise = ln_rise[0];
    assign clk_fall = ln_fall[0];
    assign rst_cur  = ln_cur[1];
    assign rst_rise = ln_rise[1];
    assign rst_fall = ln_fall[1];
    assign io_cur   = ln_cur[2];
    assign start_c  = ln_fall[2] & clk_cur;
    assign stop_c   = ln_rise[2] & clk_cur;

    // Store read: current pointer before the first bit, next pointer after
    logic [PTR_W-1:0] ptr_inc;
    logic [IDX_W-1:0] rd_idx;
    logic             rd_bit;
    assign ptr_inc = state_q.ptr + 1'b1;
    assign rd_idx  = state_q.first ? state_q.ptr[IDX_W-1:0] : ptr_inc[IDX_W-1:0];

    mcard_store #(.ADDR_W(ADDR_W), .PROT_BITS(PROT_BITS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mem_wr_en),
        .wr_prot(mem_wr_prot),
        .wr_addr(mem_wr_addr),
        .wr_data(mem_wr_data),
        .rd_prot(state_q.src_prot),
        .rd_idx (rd_idx),
        .rd_bit (rd_bit)
    );

    logic [7:0]        ctl;
    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_data;
    assign ctl      = state_q.shreg[7:0];
    assign cmd_addr = state_q.shreg[8 +: ADDR_W];
    assign cmd_data = state_q.shreg[23:16];

    always_comb begin
        state_d = state_q;
        if (state_q.upd_req && upd_done) begin
            state_d.upd_req   = 1'b0;
            state_d.done_seen = 1'b1;
        end
        if (rst_cur) begin
            state_d.mode      = MD_HOLD;
            state_d.io_oe     = 1'b0;
            state_d.io_out    = 1'b1;
            state_d.upd_req   = 1'b0;
            state_d.done_seen = 1'b0;
            state_d.ptr       = '0;
            state_d.first     = 1'b1;
            state_d.src_prot  = 1'b0;
            state_d.atr_arm   = rst_rise ? 1'b0 : (state_q.atr_arm | clk_rise);
        end else if (rst_fall) begin
            state_d.atr_arm = 1'b0;
            if (state_q.atr_arm) begin
                state_d.mode   = MD_ATR;
                state_d.io_oe  = 1'b1;
                state_d.io_out = rd_bit;
                state_d.first  = 1'b0;
                state_d.last   = PTR_W'(ATR_BITS);
            end else begin
                state_d.mode = MD_IDLE;
            end
        end else begin
            case (state_q.mode)
                MD_IDLE: begin
                    if (start_c) begin
                        state_d.mode  = MD_RECV;
                        state_d.cnt   = '0;
                        state_d.shreg = '0;
                    end
                end
                MD_RECV: begin
                    if (start_c) begin
                        state_d.cnt   = '0;
                        state_d.shreg = '0;
                    end else if (stop_c) begin
                        state_d.mode = MD_IDLE;
                        if (state_q.cnt == CNT_W'(FRAME_CLKS)) begin
                            case (ctl)
                                CTL_RD_MAIN: begin
                                    state_d.mode     = MD_OUT;
                                    state_d.ptr      = {1'b0, cmd_addr, 3'b000};
                                    state_d.last     = PTR_W'(MAIN_BITS);
                                    state_d.src_prot = 1'b0;
                                    state_d.first    = 1'b1;
                                end
                                CTL_RD_PROT: begin
                                    state_d.mode     = MD_OUT;
                                    state_d.ptr      = '0;
                                    state_d.last     = PTR_W'(PROT_BITS);
                                    state_d.src_prot = 1'b1;
                                    state_d.first    = 1'b1;
                                end
                                CTL_UPD_MAIN, CTL_WR_PROT: begin
                                    state_d.mode      = MD_PROC;
                                    state_d.upd_req   = 1'b1;
                                    state_d.upd_prot  = (ctl == CTL_WR_PROT);
                                    state_d.upd_addr  = cmd_addr;
                                    state_d.upd_data  = cmd_data;
                                    state_d.done_seen = 1'b0;
                                end
                                default: state_d.mode = MD_IDLE;
                            endcase
                        end
                    end else if (clk_rise) begin
                        if (state_q.cnt < CNT_W'(CMD_BITS))
                            state_d.shreg = {io_cur, state_q.shreg[CMD_BITS-1:1]};
                        if (state_q.cnt != '1)
                            state_d.cnt = state_q.cnt + 1'b1;
                    end
                end
                MD_ATR, MD_OUT: begin
                    if (clk_fall) begin
                        if (state_q.first) begin
                            state_d.first  = 1'b0;
                            state_d.io_oe  = 1'b1;
                            state_d.io_out = rd_bit;
                        end else if (ptr_inc == state_q.last) begin
                            state_d.io_oe  = 1'b0;
                            state_d.io_out = 1'b1;
                            state_d.mode   = MD_IDLE;
                        end else begin
                            state_d.ptr    = ptr_inc;
                            state_d.io_out = rd_bit;
                        end
                    end
                end
                MD_PROC: begin
                    if (clk_fall) begin
                        if (!state_q.io_oe) begin
                            state_d.io_oe  = 1'b1;
                            state_d.io_out = 1'b0;
                        end else if (state_d.done_seen) begin
                            state_d.io_oe     = 1'b0;
                            state_d.io_out    = 1'b1;
                            state_d.done_seen = 1'b0;
                            state_d.mode      = MD_IDLE;
                        end
                    end
                end
                default: state_d.mode = MD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign io_oe    = state_q.io_oe;
    assign io_out   = state_q.io_out;
    assign upd_req  = state_q.upd_req;
    assign upd_prot = state_q.upd_prot;
    assign upd_addr = state_q.upd_addr;
    assign upd_data = state_q.upd_data;

    // R2
    io_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe != $past(io_oe) || (io_oe && io_out != $past(io_out)))
        |-> $past(clk_fall || rst_rise || rst_fall));

    // R4
    recv_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.mode == MD_RECV) |-> !io_oe);

    // R5
    stream_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.mode == MD_OUT) |-> (state_q.ptr < state_q.last));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && !upd_done && !rst_cur) |=> upd_req);

    // R7
    req_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && !upd_done && !rst_cur) |=> ($stable(upd_addr) && $stable(upd_data) && $stable(upd_prot)));

    // R9
    break_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cur |=> (!io_oe && !upd_req));
endmodule

// File: tb/mcard_engine_test.sv
`timescale 1ns/1ps
module mcard_engine_test;
    localparam int PH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       card_rst = 1'b0;
    logic       card_clk = 1'b0;
    logic       ifd_io = 1'b1;
    logic       io_line;
    logic       io_oe, io_out;
    logic       upd_req, upd_prot, upd_done = 1'b0;
    logic [7:0] upd_addr, upd_data;
    logic       mem_wr_en = 1'b0, mem_wr_prot = 1'b0;
    logic [7:0] mem_wr_addr = '0, mem_wr_data = '0;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  exp_main [256];
    logic [31:0] exp_prot;

    always #5 clk = ~clk;

    assign io_line = ifd_io & (io_oe ? io_out : 1'b1);

    mcard_engine uut (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .card_clk(card_clk),
        .io_in(io_line), .io_oe(io_oe), .io_out(io_out),
        .upd_req(upd_req), .upd_prot(upd_prot), .upd_addr(upd_addr),
        .upd_data(upd_data), .upd_done(upd_done),
        .mem_wr_en(mem_wr_en), .mem_wr_prot(mem_wr_prot),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse();
        card_clk = 1'b1; wt(PH);
        card_clk = 1'b0; wt(PH);
    endtask

    task automatic mem_write(logic prot, logic [7:0] a, logic [7:0] d);
        mem_wr_en = 1'b1; mem_wr_prot = prot; mem_wr_addr = a; mem_wr_data = d;
        wt(1);
        mem_wr_en = 1'b0;
        if (!prot) exp_main[a] = d;
        else if (a < 32) exp_prot[a[4:0]] = d[0];
    endtask

    // Frame: start, nbits data clocks, stop in the high phase of the next clock
    task automatic send_cmd(logic [7:0] c, logic [7:0] a, logic [7:0] d, int nbits);
        logic [23:0] fr;
        fr = {d, a, c};
        ifd_io = 1'b1; wt(2);
        card_clk = 1'b1; wt(PH/2);
        ifd_io = 1'b0; wt(PH/2);
        card_clk = 1'b0; wt(PH);
        for (int i = 0; i < nbits; i++) begin
            ifd_io = (i < 24) ? fr[i] : 1'b0;
            wt(2);
            pulse();
        end
        ifd_io = 1'b0; wt(2);
        card_clk = 1'b1; wt(PH/2);
        ifd_io = 1'b1; wt(PH/2);
        card_clk = 1'b0; wt(PH);
    endtask

    function automatic logic exp_bit(logic prot, int idx);
        if (prot) return exp_prot[idx];
        return exp_main[idx >> 3][idx & 7];
    endfunction

    // Expects bit 0 already on the line; glitch adds start/stop during 1 bits
    task automatic read_expect(string tag, logic prot, int start, int nbits, logic glitch);
        for (int i = 0; i < nbits; i++) begin
            logic b;
            b = exp_bit(prot, start + i);
            chk(tag, {io_oe, io_line}, {1'b1, b});
            card_clk = 1'b1; wt(PH/2);
            chk({tag, " R2 hold in high phase"}, io_line, b);
            if (glitch && b) begin
                ifd_io = 1'b0; wt(2);
                ifd_io = 1'b1; wt(PH/2 - 2);
            end else begin
                wt(PH/2);
            end
            card_clk = 1'b0; wt(PH);
        end
        chk({tag, " release"}, io_oe, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 io_oe", io_oe, 1'b0);
        chk("R1 upd_req", upd_req, 1'b0);
        chk("R1 line", io_line, 1'b1);
    endtask

    task automatic t_atr();
        card_rst = 1'b1; wt(PH);
        card_clk = 1'b1; wt(PH);
        card_clk = 1'b0; wt(PH);
        card_rst = 1'b0; wt(PH);
        read_expect("R3 R8 atr", 1'b0, 0, 32, 1'b1);
    endtask

    task automatic t_read_main();
        send_cmd(8'h30, 8'd252, 8'h00, 24);
        read_expect("R5 R8 main from 252", 1'b0, 252 * 8, 32, 1'b1);
    endtask

    task automatic t_read_prot();
        send_cmd(8'h34, 8'h00, 8'h00, 24);
        read_expect("R6 prot", 1'b1, 0, 32, 1'b1);
    endtask

    task automatic t_update(logic [7:0] c, logic [7:0] a, logic [7:0] d);
        logic pr;
        pr = (c == 8'h3C);
        send_cmd(c, a, d, 24);
        chk("R7 req", upd_req, 1'b1);
        chk("R7 prot flag", upd_prot, pr);
        chk("R7 addr", upd_addr, a);
        chk("R7 data", upd_data, d);
        chk("R7 busy low", {io_oe, io_line}, 2'b10);
        for (int i = 0; i < 3; i++) begin
            pulse();
            chk("R7 busy held", {upd_req, io_line}, 2'b10);
        end
        if (pr) mem_write(1'b1, a, 8'h00);
        else    mem_write(1'b0, a, d);
        upd_done = 1'b1; wt(1);
        upd_done = 1'b0; wt(1);
        chk("R7 req dropped", upd_req, 1'b0);
        chk("R7 still low before fall", io_line, 1'b0);
        pulse();
        chk("R7 released", io_oe, 1'b0);
    endtask

    task automatic t_bad(string tag, logic [7:0] c, int nbits);
        send_cmd(c, 8'h00, 8'h00, nbits);
        for (int i = 0; i < 9; i++) begin
            chk(tag, {io_oe, upd_req}, 2'b00);
            pulse();
        end
        send_cmd(8'h34, 8'h00, 8'h00, 24);
        chk({tag, " recovers"}, {io_oe, io_line}, {1'b1, exp_prot[0]});
        for (int i = 0; i < 33; i++) pulse();
        chk({tag, " recovered release"}, io_oe, 1'b0);
    endtask

    task automatic t_break();
        send_cmd(8'h30, 8'h00, 8'h00, 24);
        chk("R9 pre-break first bit", {io_oe, io_line}, {1'b1, exp_main[0][0]});
        for (int i = 0; i < 4; i++) pulse();
        card_rst = 1'b1; wt(PH);
        chk("R9 release during break", io_oe, 1'b0);
        card_rst = 1'b0; wt(PH);
        for (int i = 0; i < 3; i++) begin
            chk("R9 no atr after break", io_oe, 1'b0);
            pulse();
        end
        send_cmd(8'h30, 8'd254, 8'h00, 24);
        read_expect("R9 read after break", 1'b0, 254 * 8, 16, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) exp_main[i] = 8'hFF;
        exp_prot = '1;
        wt(5);
        rst_n = 1'b1;
        wt(4);
        t_reset();

        // R11: load through the store port
        mem_write(1'b0, 8'd0, 8'hA5);
        mem_write(1'b0, 8'd1, 8'h3C);
        mem_write(1'b0, 8'd2, 8'h0F);
        mem_write(1'b0, 8'd3, 8'h81);
        mem_write(1'b0, 8'd252, 8'h96);
        mem_write(1'b0, 8'd253, 8'h01);
        mem_write(1'b0, 8'd254, 8'hE7);
        mem_write(1'b0, 8'd255, 8'h5B);
        mem_write(1'b1, 8'd3, 8'h00);
        mem_write(1'b1, 8'd7, 8'h00);
        mem_write(1'b1, 8'd20, 8'h00);
        mem_write(1'b1, 8'd31, 8'h00);

        t_atr();
        t_read_main();
        t_read_prot();
        t_update(8'h38, 8'd255, 8'h5A);
        send_cmd(8'h30, 8'd255, 8'h00, 24);
        read_expect("R11 R7 updated byte", 1'b0, 255 * 8, 8, 1'b0);
        t_update(8'h3C, 8'd12, 8'h77);
        t_read_prot();
        t_bad("R10 unknown control", 8'h31, 24);
        t_bad("R10 short frame", 8'h30, 23);
        t_bad("R10 long frame", 8'h30, 25);
        t_break();

        summary();
        $finish;
    end
endmodule